// File: doc/BRIEF.md
# Adaptive Compression Allocation Predictor

This block decides whether a compressed cache should store newly allocated lines in compressed or uncompressed form. The cache reports every access to it. Each report gives the depth of the referenced tag in the replacement stack, whether the access hit, whether a tag matched even though its data is absent, whether the line is stored compressed, and the total number of data segments the set's tags would need if every line up to and including the referenced one were compressed.

Each access is judged against the associativity that an uncompressed cache of the same data size would have. An access is a cost when compression only added decompression delay. It is a benefit when compression avoided an off-chip miss, or would have avoided one. Otherwise it is neutral. A single signed saturating counter keeps the running balance. Benefits add the memory latency and costs subtract the decompression latency. In an optional normalised mode the weights are the latency ratio and one. The counter's sign gives the allocation decision.

Top module: `cmp_alloc_predictor`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted, and after it is released, the counter `predCount` reads zero and `compressAlloc` reads 1.
- R2: A hit whose `stackDepth` (0 = most recent) is below the uncompressed way count (default 2) on a line with `lineCompressed` = 0 leaves the counter unchanged.
- R3: A hit with `stackDepth` below the uncompressed way count on a line with `lineCompressed` = 1 subtracts the cost weight on the next clock edge.
- R4: A hit with `stackDepth` at or above the uncompressed way count adds the benefit weight on the next clock edge, whatever the value of `lineCompressed`.
- R5: A miss with `tagPresent` = 1 and `segSum` at most the set's segment capacity (default 16) adds the benefit weight. If `segSum` exceeds the capacity, the counter is unchanged.
- R6: A miss with `tagPresent` = 0 leaves the counter unchanged, whatever the other inputs are.
- R7: While `accValid` is 0, the counter holds its value, whatever the other access inputs are.
- R8: An update that would exceed the largest 19-bit two's-complement value (262143) leaves the counter at 262143.
- R9: An update that would go below the smallest value (-262144) leaves the counter at -262144.
- R10: `compressAlloc` is 1 when the counter is zero or positive and 0 when it is negative. It changes in the same cycle as the counter.
- R11: With `normMode` = 0, the benefit weight is `memLatency` and the cost weight is `decompLatency`. With `normMode` = 1, the benefit weight is `memLatency / decompLatency` (integer quotient, or `memLatency` itself when `decompLatency` is 0) and the cost weight is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | One cache access is reported this cycle |
| accHit | input | 1 | The access hit |
| stackDepth | input | 3 | Replacement-stack depth of the matching tag, 0 = most recent |
| tagPresent | input | 1 | A tag matched although the data is absent |
| lineCompressed | input | 1 | The hit line is stored compressed |
| segSum | input | 6 | Segments needed by all tags down to this depth if compressed |
| memLatency | input | 16 | Off-chip miss latency, used as the benefit weight |
| decompLatency | input | 16 | Decompression latency, used as the cost weight |
| normMode | input | 1 | Select the normalised weights |
| compressAlloc | output | 1 | Allocate new lines compressed |
| predCount | output | 19 | Current two's-complement balance |

## Verification
Two of the block's functions can act on the same clock edge. The first is a weighted update together with the clamp, when the counter sits a few steps from a bound and the next weight overshoots it. The second is a weighted update together with the sign-based decision, when that update carries the counter across zero. The bench provokes the first by driving five and then nine large-weight accesses toward each limit. It judges the result by the exact clamped value and by one further access that must leave the counter pinned. It provokes the second by choosing the decompression latency so that one cost lands exactly on zero and the next lands below it. The decision is then sampled after the same edge that updates the counter.

// File: rtl/cmp_pred_pkg.sv
package cmp_pred_pkg;

  typedef enum logic [1:0] {
    ACC_NEUTRAL = 2'd0,
    ACC_COST    = 2'd1,
    ACC_BENEFIT = 2'd2
  } accClass_e;

  // strobes from the classifier to the counter datapath
  typedef struct packed {
    logic addBenefit;
    logic subCost;
  } predStrobe_t;

endpackage

// File: rtl/cmp_pred_classify.sv
module cmp_pred_classify
  import cmp_pred_pkg::*;
#(
  parameter int DEPTH_W   = 3,
  parameter int UNC_WAYS  = 2,
  parameter int SEG_W     = 6,
  parameter int SEG_TOTAL = 16
) (
  input  logic               accValid,
  input  logic               accHit,
  input  logic [DEPTH_W-1:0] stackDepth,
  input  logic               tagPresent,
  input  logic               lineCompressed,
  input  logic [SEG_W-1:0]   segSum,
  output predStrobe_t        strobe
);

  localparam logic [DEPTH_W-1:0] UNC_IDX = DEPTH_W'(UNC_WAYS);
  localparam logic [SEG_W-1:0]   SEG_LIM = SEG_W'(SEG_TOTAL);

  accClass_e accClass;
  logic      withinUnc;
  logic      fitsSet;

  assign withinUnc = stackDepth < UNC_IDX;
  assign fitsSet   = segSum <= SEG_LIM;

  always_comb begin
    accClass = ACC_NEUTRAL;
    if (accValid) begin
      if (accHit) begin
        if (!withinUnc)          accClass = ACC_BENEFIT; // avoided miss
        else if (lineCompressed) accClass = ACC_COST;    // penalised hit
      end else if (tagPresent && fitsSet) begin
        accClass = ACC_BENEFIT;                          // avoidable miss
      end
    end
  end

  always_comb begin
    strobe.addBenefit = (accClass == ACC_BENEFIT);
    strobe.subCost    = (accClass == ACC_COST);
  end

endmodule

// File: rtl/cmp_pred_counter.sv
module cmp_pred_counter
  import cmp_pred_pkg::*;
#(
  parameter int CNT_W        = 19,
  parameter int LAT_W        = 16,
  parameter bit NORM_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  predStrobe_t      strobe,
  input  logic [LAT_W-1:0] memLatency,
  input  logic [LAT_W-1:0] decompLatency,
  input  logic             normMode,
  output logic [CNT_W-1:0] predCount,
  output logic             compressAlloc
);

  localparam int EXT_W = CNT_W + 2;
  localparam logic signed [EXT_W-1:0] MAX_V = {3'b000, {(CNT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MIN_V = {3'b111, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0]        cntQ;
  logic [LAT_W-1:0]        benW;
  logic [LAT_W-1:0]        costW;
  logic signed [EXT_W-1:0] cntExt;
  logic signed [EXT_W-1:0] benExt;
  logic signed [EXT_W-1:0] costExt;
  logic signed [EXT_W-1:0] sumExt;
  logic [CNT_W-1:0]        cntD;

  generate
    if (NORM_SUPPORT) begin : g_norm
      logic [LAT_W-1:0] ratio;
      assign ratio = (decompLatency == '0) ? memLatency
                                           : (memLatency / decompLatency);
      assign benW  = normMode ? ratio : memLatency;
      assign costW = normMode ? LAT_W'(1) : decompLatency;
    end else begin : g_raw
      logic unusedMode;
      assign unusedMode = normMode;
      assign benW  = memLatency;
      assign costW = decompLatency;
    end
  endgenerate

  assign cntExt  = {{2{cntQ[CNT_W-1]}}, cntQ};
  assign benExt  = strobe.addBenefit ? {{(EXT_W-LAT_W){1'b0}}, benW}  : '0;
  assign costExt = strobe.subCost    ? {{(EXT_W-LAT_W){1'b0}}, costW} : '0;
  assign sumExt  = cntExt + benExt - costExt;

  always_comb begin
    if (sumExt > MAX_V)      cntD = MAX_V[CNT_W-1:0];
    else if (sumExt < MIN_V) cntD = MIN_V[CNT_W-1:0];
    else                     cntD = sumExt[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntD;
  end

  assign predCount     = cntQ;
  assign compressAlloc = ~cntQ[CNT_W-1];

endmodule

// File: rtl/cmp_alloc_predictor.sv
module cmp_alloc_predictor
  import cmp_pred_pkg::*;
#(
  parameter int CNT_W        = 19,
  parameter int LAT_W        = 16,
  parameter int DEPTH_W      = 3,
  parameter int UNC_WAYS     = 2,
  parameter int SEG_W        = 6,
  parameter int SEG_TOTAL    = 16,
  parameter bit NORM_SUPPORT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accHit,
  input  logic [DEPTH_W-1:0] stackDepth,
  input  logic               tagPresent,
  input  logic               lineCompressed,
  input  logic [SEG_W-1:0]   segSum,
  input  logic [LAT_W-1:0]   memLatency,
  input  logic [LAT_W-1:0]   decompLatency,
  input  logic               normMode,
  output logic               compressAlloc,
  output logic [CNT_W-1:0]   predCount
);

  predStrobe_t strobe;

  cmp_pred_classify #(
    .DEPTH_W  (DEPTH_W),
    .UNC_WAYS (UNC_WAYS),
    .SEG_W    (SEG_W),
    .SEG_TOTAL(SEG_TOTAL)
  ) i_classify (
    .accValid      (accValid),
    .accHit        (accHit),
    .stackDepth    (stackDepth),
    .tagPresent    (tagPresent),
    .lineCompressed(lineCompressed),
    .segSum        (segSum),
    .strobe        (strobe)
  );

  cmp_pred_counter #(
    .CNT_W       (CNT_W),
    .LAT_W       (LAT_W),
    .NORM_SUPPORT(NORM_SUPPORT)
  ) i_counter (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .memLatency   (memLatency),
    .decompLatency(decompLatency),
    .normMode     (normMode),
    .predCount    (predCount),
    .compressAlloc(compressAlloc)
  );

endmodule

// File: rtl/cmp_alloc_predictor_chk.sv
module cmp_alloc_predictor_chk #(
  parameter int CNT_W    = 19,
  parameter int DEPTH_W  = 3,
  parameter int UNC_WAYS = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               accValid,
  input logic               accHit,
  input logic [DEPTH_W-1:0] stackDepth,
  input logic               tagPresent,
  input logic               lineCompressed,
  input logic [CNT_W-1:0]   predCount
);

  localparam logic [DEPTH_W-1:0] UNC_IDX = DEPTH_W'(UNC_WAYS);

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |-> predCount == '0);

  assert_plain_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accHit && (stackDepth < UNC_IDX) && !lineCompressed
    |=> $stable(predCount));

  assert_cost_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accHit && (stackDepth < UNC_IDX) && lineCompressed
    |=> $signed(predCount) <= $signed($past(predCount)));

  assert_benefit_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accHit && (stackDepth >= UNC_IDX)
    |=> $signed(predCount) >= $signed($past(predCount)));

  assert_untagged_miss_R6: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !accHit && !tagPresent |=> $stable(predCount));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> $stable(predCount));

endmodule

bind cmp_alloc_predictor cmp_alloc_predictor_chk #(
  .CNT_W   (CNT_W),
  .DEPTH_W (DEPTH_W),
  .UNC_WAYS(UNC_WAYS)
) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .accValid      (accValid),
  .accHit        (accHit),
  .stackDepth    (stackDepth),
  .tagPresent    (tagPresent),
  .lineCompressed(lineCompressed),
  .predCount     (predCount)
);

// File: tb/test_cmp_alloc_predictor.sv
module test_cmp_alloc_predictor;

  localparam int MAXV = 262143;
  localparam int MINV = -262144;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accHit = 1'b0;
  logic [2:0]  stackDepth = '0;
  logic        tagPresent = 1'b0;
  logic        lineCompressed = 1'b0;
  logic [5:0]  segSum = '0;
  logic [15:0] memLatency = '0;
  logic [15:0] decompLatency = '0;
  logic        normMode = 1'b0;
  logic        compressAlloc;
  logic [18:0] predCount;

  int total = 0;
  int bad = 0;
  int expCnt = 0;

  always #10 clk = ~clk;

  cmp_alloc_predictor i_cmp_alloc_predictor (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit),
    .stackDepth(stackDepth), .tagPresent(tagPresent),
    .lineCompressed(lineCompressed), .segSum(segSum),
    .memLatency(memLatency), .decompLatency(decompLatency),
    .normMode(normMode), .compressAlloc(compressAlloc), .predCount(predCount)
  );

  function automatic int clampIt(int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic checkState(string req);
    int got;
    got = $signed(predCount);
    total++;
    if (got != expCnt) begin
      bad++;
      $display("FAIL %s count actual=%0d expected=%0d", req, got, expCnt);
    end
    total++;
    if (compressAlloc !== (expCnt >= 0)) begin
      bad++;
      $display("FAIL %s decision actual=%0b expected=%0b", req, compressAlloc, expCnt >= 0);
    end
  endtask

  // one access: driven after a falling edge, applied at the rising edge,
  // outputs sampled at the following falling edge
  task automatic acc(input logic hit, input int depth, input logic tag,
                     input logic comp, input int seg);
    accValid = 1'b1; accHit = hit; stackDepth = 3'(depth);
    tagPresent = tag; lineCompressed = comp; segSum = 6'(seg);
    @(posedge clk);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    expCnt = 0;
    checkState("R1");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1");
  endtask

  task automatic t_hits();
    normMode = 1'b0; memLatency = 16'd100; decompLatency = 16'd5;
    acc(1'b1, 2, 1'b0, 1'b0, 0); expCnt = 100; checkState("R4 avoided miss depth 2");
    acc(1'b1, 3, 1'b0, 1'b1, 0); expCnt = 200; checkState("R4 avoided miss compressed");
    acc(1'b1, 1, 1'b0, 1'b0, 0); checkState("R2 plain hit depth 1");
    acc(1'b1, 0, 1'b1, 1'b0, 0); checkState("R2 plain hit depth 0");
    acc(1'b1, 1, 1'b0, 1'b1, 0); expCnt = 195; checkState("R3 penalised hit");
  endtask

  task automatic t_misses();
    acc(1'b0, 3, 1'b1, 1'b0, 15); expCnt = 295; checkState("R5 avoidable miss 15");
    acc(1'b0, 3, 1'b1, 1'b0, 16); expCnt = 395; checkState("R5 avoidable miss at capacity");
    acc(1'b0, 3, 1'b1, 1'b0, 17); checkState("R5 over capacity");
    acc(1'b0, 3, 1'b0, 1'b0, 4);  checkState("R6 untagged miss");
    acc(1'b0, 1, 1'b0, 1'b1, 0);  checkState("R6 untagged miss compressed");
  endtask

  task automatic t_idle();
    accHit = 1'b1; stackDepth = 3'd3; tagPresent = 1'b1; segSum = 6'd2;
    repeat (4) @(negedge clk);
    checkState("R7 idle hold");
  endtask

  task automatic t_sign();
    decompLatency = 16'd395;
    acc(1'b1, 0, 1'b0, 1'b1, 0); expCnt = 0;    checkState("R10 cost to zero");
    acc(1'b1, 0, 1'b0, 1'b1, 0); expCnt = -395; checkState("R10 cost below zero");
    memLatency = 16'd395;
    acc(1'b1, 4, 1'b0, 1'b0, 0); expCnt = 0;    checkState("R10 benefit back to zero");
  endtask

  task automatic t_norm();
    normMode = 1'b1; memLatency = 16'd100; decompLatency = 16'd7;
    acc(1'b1, 2, 1'b0, 1'b0, 0); expCnt = 14;  checkState("R11 normalised benefit");
    acc(1'b1, 1, 1'b0, 1'b1, 0); expCnt = 13;  checkState("R11 normalised cost");
    decompLatency = 16'd0;
    acc(1'b0, 2, 1'b1, 1'b0, 8); expCnt = 113; checkState("R11 zero divisor");
    normMode = 1'b0;
  endtask

  task automatic t_sat();
    memLatency = 16'd60000; decompLatency = 16'd60000;
    for (int i = 0; i < 5; i++) begin
      acc(1'b1, 5, 1'b0, 1'b0, 0);
      expCnt = clampIt(expCnt + 60000);
    end
    checkState("R8 clamp at max");
    acc(1'b1, 5, 1'b0, 1'b0, 0); checkState("R8 held at max");
    for (int i = 0; i < 9; i++) begin
      acc(1'b1, 0, 1'b0, 1'b1, 0);
      expCnt = clampIt(expCnt - 60000);
    end
    checkState("R9 clamp at min");
    acc(1'b1, 1, 1'b0, 1'b1, 0); checkState("R9 held at min");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    t_hits();
    t_misses();
    t_idle();
    t_sign();
    t_norm();
    doReset();
    t_sat();
    doReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule